// File: doc/BRIEF.md
# Lockable PWM Output-Level Control Register

This block is an 8-bit control register that sits beside a complementary PWM engine. Software writes it over a simple strobe bus. The register picks the level for the positive phase and the level for the negative phase. It can take those levels from its own bits or from a second level register, whose two bits arrive as inputs. The chosen levels are driven as the initial pin levels while the timer counter is stopped, so the pins settle at known values before the PWM engine takes over.

A lock bit can be set only once per reset. Once set, it freezes the two level bits and the source-select bit. Software that runs away cannot then change the pin polarity. The toggle-enable bit stays writable at all times. While that bit is set, a toggle output flips once on each PWM period pulse. When dead-time generation is off, the negative phase is taken as the exact inverse of the positive phase, and only the positive-phase bit matters.

Top module: `pwm_level_ctrl`

## Requirements
- R1: After a synchronous reset, every register bit reads 0, and `pos_level`, `neg_level` and `toggle_out` are 0.
- R2: Register layout: bit 0 is the positive-phase level, bit 1 is the negative-phase level, bit 2 is the source select, bit 3 is the lock, and bit 6 is the toggle enable. When `rd_sel` is 1, `rd_data` returns the register value in the same cycle. When `rd_sel` is 0, `rd_data` is 0. A write (`wr_en` = 1) updates the register at the next clock edge.
- R3: Bits 7, 5 and 4 always read as 0, whatever was written to them.
- R4: If the lock reads 1 before a write, that write leaves bits 0, 1 and 2 unchanged. A write that sets the lock still updates bits 0 to 2 with its data in the same cycle.
- R5: Once set, the lock stays 1 until the next reset, even if 0 is written to it. A reset clears it.
- R6: Bit 6 takes the written value on every write, whether or not the lock is set.
- R7: If source select is 0, the selected levels are bits 0 and 1. If it is 1, they are `alt_pos_lvl` and `alt_neg_lvl`.
- R8: If `deadtime_enable` is 0, the negative level is the inverse of the selected positive level. If it is 1, the negative level is the selected negative level.
- R9: `pos_level` and `neg_level` are registered. While `counter_running` is 0, each clock edge loads them from the register and inputs as they were before that edge. While `counter_running` is 1, they hold their values.
- R10: `toggle_out` inverts at a clock edge when `pwm_period_pulse` is 1 and the toggle enable, as it was before that edge, is 1. Otherwise it holds its value. A write that clears the enable does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read address match; enables `rd_data` |
| rd_data | output | 8 | Combinational read data |
| counter_running | input | 1 | PWM counter is running |
| deadtime_enable | input | 1 | Dead-time generation is active |
| pwm_period_pulse | input | 1 | One pulse per PWM period |
| alt_pos_lvl | input | 1 | Positive level from the second level register |
| alt_neg_lvl | input | 1 | Negative level from the second level register |
| pos_level | output | 1 | Positive-phase initial level |
| neg_level | output | 1 | Negative-phase initial level |
| toggle_out | output | 1 | Period-synchronized toggle output |

## Verification
The bench goes after the corner cases of the lock:
- A write that sets the lock and changes the levels in the same cycle. A design that checked the incoming lock bit instead of the stored one would drop those levels.
- Later writes of 0 to the lock. A design that allowed them would let locked fields change again.
- A reset, which must clear the lock.

It writes the toggle enable under lock, and clears it in the same cycle as a period pulse. A design that gated the enable with the lock, or used the post-write enable, would miss or add a flip. It also runs with the counter running, with the source select at 1, and with dead-time off. These catch levels that leak through while the counter runs, a swapped source, and a negative phase that does not follow the positive phase.

// File: rtl/pwm_level_pkg.sv
package pwm_level_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned B_POS    = 0;
  localparam int unsigned B_NEG    = 1;
  localparam int unsigned B_SRC    = 2;
  localparam int unsigned B_LOCK   = 3;
  localparam int unsigned B_TOGEN  = 6;
  localparam logic [REG_W-1:0] RSV_MASK = 8'hB0;

  typedef struct packed {
    logic pos;
    logic neg;
    logic src;
  } lvl_fields_t;
endpackage

// File: rtl/lvl_reg_bank.sv
module lvl_reg_bank
  import pwm_level_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output lvl_fields_t      fields,
  output logic             lock,
  output logic             tog_en
);
  lvl_fields_t fld_q;
  logic        lock_q;
  logic        togen_q;
  logic [REG_W-1:0] image;

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q   <= '0;
      lock_q  <= 1'b0;
      togen_q <= 1'b0;
    end else if (wr_en) begin
      if (!lock_q) begin
        fld_q.pos <= wr_data[B_POS];
        fld_q.neg <= wr_data[B_NEG];
        fld_q.src <= wr_data[B_SRC];
      end
      if (wr_data[B_LOCK]) lock_q <= 1'b1;
      togen_q <= wr_data[B_TOGEN];
    end
  end

  always_comb begin
    image          = '0;
    image[B_POS]   = fld_q.pos;
    image[B_NEG]   = fld_q.neg;
    image[B_SRC]   = fld_q.src;
    image[B_LOCK]  = lock_q;
    image[B_TOGEN] = togen_q;
    rd_data        = rd_sel ? image : '0;
  end

  assign fields = fld_q;
  assign lock   = lock_q;
  assign tog_en = togen_q;

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  assert_locked_fields_R4: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(fld_q));
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RSV_MASK) == '0);
endmodule

// File: rtl/lvl_output_sel.sv
module lvl_output_sel
  import pwm_level_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lvl_fields_t fields,
  input  logic        alt_pos,
  input  logic        alt_neg,
  input  logic        dt_en,
  input  logic        running,
  output logic        pos_q,
  output logic        neg_q
);
  logic sel_pos, sel_neg, neg_eff;

  always_comb begin
    sel_pos = fields.src ? alt_pos : fields.pos;
    sel_neg = fields.src ? alt_neg : fields.neg;
    neg_eff = dt_en ? sel_neg : ~sel_pos;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (!running) begin
      pos_q <= sel_pos;
      neg_q <= neg_eff;
    end
  end

  assert_hold_running_R9: assert property (@(posedge clk) disable iff (rst)
    running |=> ($stable(pos_q) && $stable(neg_q)));
  assert_inverse_nodt_R8: assert property (@(posedge clk) disable iff (rst)
    (!running && !dt_en) |=> (neg_q != pos_q));
endmodule

// File: rtl/sync_toggle.sv
module sync_toggle (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic period_pulse,
  output logic tog_q
);
  always_ff @(posedge clk) begin
    if (rst)                        tog_q <= 1'b0;
    else if (enable && period_pulse) tog_q <= ~tog_q;
  end

  assert_toggle_flip_R10: assert property (@(posedge clk) disable iff (rst)
    (enable && period_pulse) |=> (tog_q != $past(tog_q)));
  assert_toggle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(enable && period_pulse) |=> $stable(tog_q));
endmodule

// File: rtl/pwm_level_ctrl.sv
module pwm_level_ctrl
  import pwm_level_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             counter_running,
  input  logic             deadtime_enable,
  input  logic             pwm_period_pulse,
  input  logic             alt_pos_lvl,
  input  logic             alt_neg_lvl,
  output logic             pos_level,
  output logic             neg_level,
  output logic             toggle_out
);
  lvl_fields_t fields;
  logic        lock;
  logic        tog_en;

  lvl_reg_bank u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .fields(fields),
    .lock(lock), .tog_en(tog_en)
  );

  lvl_output_sel u_out (
    .clk(clk), .rst(rst), .fields(fields), .alt_pos(alt_pos_lvl),
    .alt_neg(alt_neg_lvl), .dt_en(deadtime_enable),
    .running(counter_running), .pos_q(pos_level), .neg_q(neg_level)
  );

  sync_toggle u_tog (
    .clk(clk), .rst(rst), .enable(tog_en),
    .period_pulse(pwm_period_pulse), .tog_q(toggle_out)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !pos_level && !neg_level && !toggle_out));
endmodule

// File: tb/tb_pwm_level_ctrl.sv
module tb_pwm_level_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic run = 1'b0, dt = 1'b1, pls = 1'b0, ap = 1'b0, an = 1'b0;
  logic pos_level, neg_level, toggle_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic m_pos, m_neg, m_src, m_lock, m_ten;
  logic e_pos, e_neg, e_tog;

  always #5 clk = ~clk;

  pwm_level_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .counter_running(run), .deadtime_enable(dt),
    .pwm_period_pulse(pls), .alt_pos_lvl(ap), .alt_neg_lvl(an),
    .pos_level(pos_level), .neg_level(neg_level), .toggle_out(toggle_out)
  );

  function automatic logic [7:0] model_image();
    logic [7:0] v;
    v = 8'h00;
    v[0] = m_pos; v[1] = m_neg; v[2] = m_src; v[3] = m_lock; v[6] = m_ten;
    return v;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pos = 0; m_neg = 0; m_src = 0; m_lock = 0; m_ten = 0;
    e_pos = 0; e_neg = 0; e_tog = 0;
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; wr_en = 0; rd_sel = 1; pls = 0; run = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check(tag, "rd_data", rd_data, 8'h00);
    check(tag, "pos", {7'd0, pos_level}, 8'h00);
    check(tag, "neg", {7'd0, neg_level}, 8'h00);
    check(tag, "tog", {7'd0, toggle_out}, 8'h00);
  endtask

  // Drives one cycle of inputs at a falling edge and checks one cycle later.
  task automatic step(input logic w, input logic [7:0] d, input logic rs,
                      input logic r, input logic de, input logic p,
                      input logic a_p, input logic a_n, input string tag);
    logic sp, sn;
    wr_en = w; wr_data = d; rd_sel = rs; run = r; dt = de; pls = p;
    ap = a_p; an = a_n;
    sp = m_src ? a_p : m_pos;
    sn = m_src ? a_n : m_neg;
    if (!r) begin
      e_pos = sp;
      e_neg = de ? sn : ~sp;
    end
    if (m_ten && p) e_tog = ~e_tog;
    if (w) begin
      if (!m_lock) begin m_pos = d[0]; m_neg = d[1]; m_src = d[2]; end
      if (d[3]) m_lock = 1'b1;
      m_ten = d[6];
    end
    @(posedge clk);
    @(negedge clk);
    check("R2", "rd_data", rd_data, rs ? model_image() : 8'h00);
    check("R3", "reserved", rd_data & 8'hB0, 8'h00);
    check(tag, "pos", {7'd0, pos_level}, {7'd0, e_pos});
    check(tag, "neg", {7'd0, neg_level}, {7'd0, e_neg});
    check(tag, "tog", {7'd0, toggle_out}, {7'd0, e_tog});
    wr_en = 0; pls = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    model_reset();
    @(negedge clk);
    do_reset("R1");
    // R7: source select picks the second register's levels, then own bits
    step(1, 8'h07, 1, 0, 1, 0, 0, 1, "R7");
    step(0, 8'h00, 1, 0, 1, 0, 0, 1, "R7");
    step(0, 8'h00, 1, 0, 1, 0, 1, 0, "R7");
    step(1, 8'h01, 1, 0, 1, 0, 1, 1, "R7");
    step(0, 8'h00, 1, 0, 1, 0, 1, 1, "R7");
    // R8: dead-time off makes the negative phase the inverse
    step(0, 8'h00, 1, 0, 0, 0, 0, 0, "R8");
    step(1, 8'h02, 1, 0, 0, 0, 0, 0, "R8");
    step(0, 8'h00, 1, 0, 0, 0, 0, 0, "R8");
    // R9: levels hold while the counter runs
    step(1, 8'h03, 1, 1, 1, 0, 0, 0, "R9");
    step(1, 8'h00, 1, 1, 1, 0, 0, 0, "R9");
    step(0, 8'h00, 1, 0, 1, 0, 0, 0, "R9");
    // R3/R6: reserved bits read 0, toggle enable stored
    step(1, 8'hF0, 1, 0, 1, 0, 0, 0, "R3");
    step(1, 8'hB0, 1, 0, 1, 0, 0, 0, "R6");
    // R4: setting the lock while writing levels still takes them
    step(1, 8'h0A, 1, 0, 1, 0, 0, 0, "R4");
    step(1, 8'h05, 1, 0, 1, 0, 0, 0, "R4");
    step(1, 8'h00, 1, 0, 1, 0, 0, 0, "R5");
    step(1, 8'h40, 1, 0, 1, 0, 0, 0, "R6");
    step(1, 8'h04, 1, 0, 1, 0, 1, 1, "R4");
    // R10: toggle behaviour around the enable
    step(0, 8'h00, 1, 1, 1, 1, 0, 0, "R10");
    step(0, 8'h00, 1, 1, 1, 1, 0, 0, "R10");
    step(1, 8'h00, 1, 1, 1, 1, 0, 0, "R10");
    step(0, 8'h00, 1, 1, 1, 1, 0, 0, "R10");
    step(0, 8'h00, 0, 0, 1, 0, 0, 0, "R2");
    // R5: reset clears the lock, levels writable again
    do_reset("R5");
    step(1, 8'h01, 1, 0, 1, 0, 0, 0, "R5");
    step(0, 8'h00, 1, 0, 1, 0, 0, 0, "R5");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[15:8], r[2], r[3] & r[4], r[5], r[6],
           r[16], r[17], "R9");
      if (i == 1500) do_reset("R1");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule